// File: doc/BRIEF.md
# Register File with Instruction-Field Override

This block is the register storage of a small microcoded processor: eight 8-bit registers read through two combinational ports, the A bus and the B bus, and loaded from a single write-data bus. Each register has its own write strobe, so one value can be captured by several registers at once or by none. Registers 0 to 3 are visible to programs, 4 to 6 are scratch space for the microcode, and 7 holds the program counter.

In front of the storage sits an override stage. The microcode can either give the A select, the B select and the write strobes explicitly, or set one of three override controls. Each override control takes a 2-bit register number from a field of the current instruction. The destination override drives exactly one of the low four write enables. The two source overrides replace the 3-bit read selects with the zero-extended field. This lets one microinstruction serve an operation for any choice of registers.

Top module: `microreg_file`

## Requirements
- R1: While `rst_ni` is low, every register reads zero on both buses, with no clock edge needed.
- R2: On a rising clock edge, every register whose effective write enable is high loads `wr_data_i`. All other registers keep their value. Any number of enables may be high at once, including zero and all eight.
- R3: With `dst_from_ir_i` high, exactly one of registers 0 to 3 is written, namely the one numbered by `ir_dst_i`. The explicit strobes `wr_en_i[3:0]` have no effect.
- R4: With `dst_from_ir_i` high, the strobes `wr_en_i[7:4]` still write registers 4 to 7 as usual.
- R5: With `a_from_ir_i` high, the A bus shows register `{1'b0, ir_a_i}` and `asel_i` is ignored. With it low, the A bus shows register `asel_i`.
- R6: With `b_from_ir_i` high, the B bus shows register `{1'b0, ir_b_i}` and `bsel_i` is ignored. With it low, the B bus shows register `bsel_i`.
- R7: Reads are combinational. During a cycle that writes a register, both buses show the old value of that register until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes happen on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all registers |
| asel_i | input | 3 | Explicit A-port register select |
| bsel_i | input | 3 | Explicit B-port register select |
| wr_en_i | input | 8 | Explicit per-register write strobes, bit n for register n |
| dst_from_ir_i | input | 1 | Take the destination of the write from `ir_dst_i` |
| a_from_ir_i | input | 1 | Take the A select from `ir_a_i` |
| b_from_ir_i | input | 1 | Take the B select from `ir_b_i` |
| ir_dst_i | input | 2 | Destination register field of the instruction |
| ir_a_i | input | 2 | A source register field of the instruction |
| ir_b_i | input | 2 | B source register field of the instruction |
| wr_data_i | input | 8 | Write-data bus |
| a_bus_o | output | 8 | A read port |
| b_bus_o | output | 8 | B read port |

## Verification
The bench first loads a distinct value into each register, one at a time. A read-back on the wrong register then shows up as a wrong value. The write paths are tried with a sparse mixed strobe pattern, with all strobes off, and with all low strobes set together with the destination override. The last case shows whether the field really takes over from the strobes. The override also runs for every value of the destination field, with an upper strobe set, to tell apart a decoder that mishandles the upper registers from one that picks the wrong low register. The read overrides are checked with explicit selects that point at upper registers, so a missing override or a missing zero-extension gives a different value. A same-cycle write and read, and a reset asserted between clock edges, show that reads are combinational and that reset does not wait for the clock.

// File: rtl/microreg_pkg.sv
package microreg_pkg;
  localparam int FIELD_W  = 2;             // width of an instruction register field
  localparam int LOW_REGS = 2 ** FIELD_W;  // registers reachable from a field

  function automatic logic [LOW_REGS-1:0] field_onehot(input logic [FIELD_W-1:0] f);
    logic [LOW_REGS-1:0] r;
    r = '0;
    r[f] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/microreg_sel_mux.sv
module microreg_sel_mux
  import microreg_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic               use_ir_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [SEL_W-1:0]   sel_o
);
  // field is zero-extended: only the low registers are reachable
  assign sel_o = use_ir_i ? SEL_W'(field_i) : sel_i;
endmodule

// File: rtl/microreg_wen_mux.sv
module microreg_wen_mux
  import microreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                dst_from_ir_i,
  input  logic [FIELD_W-1:0]  field_i,
  input  logic [NUM_REGS-1:0] wr_en_i,
  output logic [NUM_REGS-1:0] wen_o
);
  logic [LOW_REGS-1:0] dec;
  assign dec = field_onehot(field_i);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wen
    if (g < LOW_REGS) begin : g_low
      assign wen_o[g] = dst_from_ir_i ? dec[g] : wr_en_i[g];
    end else begin : g_high
      assign wen_o[g] = wr_en_i[g];
    end
  end
endmodule

// File: rtl/microreg_store.sv
module microreg_store #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] wen_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [SEL_W-1:0]    a_sel_i,
  input  logic [SEL_W-1:0]    b_sel_i,
  output logic [DATA_W-1:0]   a_o,
  output logic [DATA_W-1:0]   b_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_q[g] <= '0;
      else if (wen_i[g]) regs_q[g] <= wr_data_i;
    end

    assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wen_i[g] |=> regs_q[g] == $past(wr_data_i));
    assert_hold_unwritten_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_i[g] |=> $stable(regs_q[g]));
  end

  assign a_o = regs_q[a_sel_i];
  assign b_o = regs_q[b_sel_i];
endmodule

// File: rtl/microreg_file.sv
module microreg_file
  import microreg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    asel_i,
  input  logic [SEL_W-1:0]    bsel_i,
  input  logic [NUM_REGS-1:0] wr_en_i,
  input  logic                dst_from_ir_i,
  input  logic                a_from_ir_i,
  input  logic                b_from_ir_i,
  input  logic [FIELD_W-1:0]  ir_dst_i,
  input  logic [FIELD_W-1:0]  ir_a_i,
  input  logic [FIELD_W-1:0]  ir_b_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   a_bus_o,
  output logic [DATA_W-1:0]   b_bus_o
);
  logic [SEL_W-1:0]    a_sel_eff, b_sel_eff;
  logic [NUM_REGS-1:0] wen_eff;

  microreg_sel_mux #(.SEL_W(SEL_W)) u_a_sel (
    .use_ir_i(a_from_ir_i), .sel_i(asel_i), .field_i(ir_a_i), .sel_o(a_sel_eff)
  );
  microreg_sel_mux #(.SEL_W(SEL_W)) u_b_sel (
    .use_ir_i(b_from_ir_i), .sel_i(bsel_i), .field_i(ir_b_i), .sel_o(b_sel_eff)
  );
  microreg_wen_mux #(.NUM_REGS(NUM_REGS)) u_wen (
    .dst_from_ir_i(dst_from_ir_i), .field_i(ir_dst_i), .wr_en_i(wr_en_i), .wen_o(wen_eff)
  );
  microreg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wen_i(wen_eff), .wr_data_i(wr_data_i),
    .a_sel_i(a_sel_eff), .b_sel_i(b_sel_eff), .a_o(a_bus_o), .b_o(b_bus_o)
  );

  assert_one_low_dst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_from_ir_i |-> ($countones(wen_eff[LOW_REGS-1:0]) == 1 && wen_eff[ir_dst_i]));
  assert_a_sel_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_from_ir_i |-> a_sel_eff < SEL_W'(LOW_REGS));
  assert_b_sel_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_from_ir_i |-> b_sel_eff < SEL_W'(LOW_REGS));
endmodule

// File: tb/microreg_file_test.sv
module microreg_file_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] asel = '0, bsel = '0;
  logic [7:0] wr_en = '0;
  logic       dst_ir = 1'b0, a_ir = 1'b0, b_ir = 1'b0;
  logic [1:0] f_dst = '0, f_a = '0, f_b = '0;
  logic [7:0] wdata = '0;
  logic [7:0] a_bus, b_bus;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [8];

  always #10 clk = ~clk;

  microreg_file uut (
    .clk_i(clk), .rst_ni(rst_n), .asel_i(asel), .bsel_i(bsel), .wr_en_i(wr_en),
    .dst_from_ir_i(dst_ir), .a_from_ir_i(a_ir), .b_from_ir_i(b_ir),
    .ir_dst_i(f_dst), .ir_a_i(f_a), .ir_b_i(f_b), .wr_data_i(wdata),
    .a_bus_o(a_bus), .b_bus_o(b_bus)
  );

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = '0; dst_ir = 0; a_ir = 0; b_ir = 0;
  endtask

  // inputs driven after negedge, write at the next posedge
  task automatic clk_write(input logic [7:0] en, input logic [7:0] d);
    @(negedge clk);
    wr_en = en; wdata = d;
    @(posedge clk); #2;
    idle();
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      asel = 3'(i); bsel = 3'(7 - i); #1;
      cmp(tag, a_bus, exp_q[i]);
      cmp(tag, b_bus, exp_q[7 - i]);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) exp_q[i] = '0;
    check_all("R1 reset state");
  endtask

  task automatic t_load_distinct();
    for (int i = 0; i < 8; i++) begin
      clk_write(8'(1 << i), 8'(8'h10 + i));
      exp_q[i] = 8'(8'h10 + i);
    end
    check_all("R2 single writes");
  endtask

  task automatic t_multi_and_none();
    clk_write(8'b1010_0101, 8'h3C);
    exp_q[0] = 8'h3C; exp_q[2] = 8'h3C; exp_q[5] = 8'h3C; exp_q[7] = 8'h3C;
    check_all("R2 multi write");
    clk_write(8'h00, 8'hFF);
    check_all("R2 no write");
  endtask

  task automatic t_dst_override();
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      dst_ir = 1; f_dst = 2'(f); wr_en = 8'h0F | 8'(8'h10 << f); wdata = 8'(8'hA0 + f);
      @(posedge clk); #2;
      idle();
      exp_q[f] = 8'(8'hA0 + f);
      exp_q[4 + f] = 8'(8'hA0 + f);
      check_all("R3 R4 destination override");
    end
  endtask

  task automatic t_read_override();
    for (int i = 0; i < 8; i++) begin
      clk_write(8'(1 << i), 8'(8'h50 + 3 * i));
      exp_q[i] = 8'(8'h50 + 3 * i);
    end
    for (int f = 0; f < 4; f++) begin
      a_ir = 1; b_ir = 1; asel = 3'd7; bsel = 3'd6; f_a = 2'(f); f_b = 2'(3 - f); #1;
      cmp("R5 A from field", a_bus, exp_q[f]);
      cmp("R6 B from field", b_bus, exp_q[3 - f]);
    end
    a_ir = 0; b_ir = 0; asel = 3'd5; bsel = 3'd4; f_a = 2'd0; f_b = 2'd1; #1;
    cmp("R5 A explicit", a_bus, exp_q[5]);
    cmp("R6 B explicit", b_bus, exp_q[4]);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wr_en = 8'h02; wdata = 8'hE7; asel = 3'd1; bsel = 3'd1; #1;
    cmp("R7 old value A before edge", a_bus, exp_q[1]);
    cmp("R7 old value B before edge", b_bus, exp_q[1]);
    @(posedge clk); #2;
    idle();
    exp_q[1] = 8'hE7;
    cmp("R7 new value after edge", a_bus, 8'hE7);
  endtask

  task automatic t_async_reset();
    @(negedge clk); #3;
    rst_n = 0; #1;
    for (int i = 0; i < 8; i++) exp_q[i] = '0;
    check_all("R1 asynchronous reset");
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_load_distinct();
    t_multi_and_none();
    t_dst_override();
    t_read_override();
    t_same_cycle();
    t_async_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule